// File: doc/BRIEF.md
# Reset-Gated Memory Chip-Enable Guard

This block sits between an address decoder and a static memory. It passes the memory's active-low chip-enable through while the system is out of reset. When the system reset asserts, for example on an undervoltage event, it blocks the path and holds the memory deselected, so that no spurious write can reach the memory. The pass path is combinational, so the gate adds no clock latency in normal operation.

A write may already be in progress when reset asserts. In that case the block keeps the path open for a short grace window, and the cycle can finish. The window ends at the first clock edge that sees chip-enable released. It also ends after a fixed number of clock ticks, whichever comes first. Once the path is blocked, it stays blocked until reset is released. The path reopens at the first clock edge that samples the released reset.

Top module: `ce_reset_gate`

## Requirements
- R1: When the last clock edge sampled `sys_rst_n` high, `ce_out_n` equals `ce_in_n` in the same cycle, and every transition of `ce_in_n` reaches the output.
- R2: When the first edge that samples `sys_rst_n` low also samples `ce_in_n` high, the path is blocked from that edge on and `ce_out_n` is 1.
- R3: During the grace window, the first edge that samples `ce_in_n` high blocks the path, and `ce_out_n` is 1 from that edge on.
- R4: The grace window lasts at most `GRACE_TICKS` clock edges after the edge that first saw reset low. After that edge plus `GRACE_TICKS` further edges with reset still low, `ce_out_n` is 1 whatever `ce_in_n` does.
- R5: A blocked path stays blocked while `sys_rst_n` remains low, and `ce_out_n` holds 1 with no low pulse, for any `ce_in_n` activity.
- R6: The path reopens at the first edge that samples `sys_rst_n` high, and not before it. From the following cycle on, `ce_out_n` follows `ce_in_n` again.
- R7: While the grace window is open, a low `ce_in_n` still reaches `ce_out_n`, so a write in progress completes.
- R8: From power-up, while reset is held low and chip-enable is inactive, the path is blocked after the first clock edge and `ce_out_n` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock that times the grace window and samples reset |
| sys_rst_n | input | 1 | System reset, active low; a low level requests the path to close |
| ce_in_n | input | 1 | Chip-enable from the decoder, active low |
| ce_out_n | output | 1 | Chip-enable to the memory, active low, forced to 1 while blocked |

## Verification
The bound checker watches on every cycle that the output follows the input out of reset and reopens one edge after release. It also checks that a high chip-enable at reset entry, or during the window, blocks the path on the next cycle. It checks that the window never exceeds its tick budget, and that a blocked path stays high until release. The low chip-enable that passes during the window, the power-up state, and the cycle in which a released reset has not yet been sampled can only be shown by the bench scenarios. The bench compares every cycle against a model that tracks only the run length of low reset samples and whether chip-enable was seen high.

// File: rtl/ce_gate_pkg.sv
package ce_gate_pkg;

  // Encoding chosen so an all-zero state is the safe, blocked one.
  typedef enum logic [1:0] {
    GATE_BLOCK = 2'd0,
    GATE_PASS  = 2'd1,
    GATE_HOLD  = 2'd2
  } gate_state_e;

endpackage

// File: rtl/ce_grace_timer.sv
module ce_grace_timer #(
  parameter int TICKS = 2500
) (
  input  logic clk,
  input  logic clear,
  input  logic advance,
  output logic expired
);

  generate
    if (TICKS <= 1) begin : g_single
      // A one-tick window expires on the first edge of the hold phase.
      assign expired = 1'b1;
    end else begin : g_count
      localparam int CNT_W = $clog2(TICKS);
      localparam logic [CNT_W-1:0] LAST = CNT_W'(TICKS - 1);

      logic [CNT_W-1:0] cnt_q;

      always_ff @(posedge clk) begin
        if (clear) begin
          cnt_q <= '0;
        end else if (advance) begin
          cnt_q <= cnt_q + 1'b1;
        end
      end

      assign expired = (cnt_q == LAST);
    end
  endgenerate

endmodule

// File: rtl/ce_gate_ctrl.sv
module ce_gate_ctrl
  import ce_gate_pkg::*;
(
  input  logic        clk,
  input  logic        sys_rst_n,
  input  logic        ce_in_n,
  input  logic        expired,
  output gate_state_e state_q,
  output logic        timer_clear,
  output logic        timer_advance,
  output logic        path_open
);

  gate_state_e state_d;

  always_comb begin
    state_d       = state_q;
    timer_clear   = 1'b0;
    timer_advance = 1'b0;
    unique case (state_q)
      GATE_PASS: begin
        if (!sys_rst_n) begin
          // Entry into reset: an idle enable closes at once, an active one gets a window.
          state_d     = ce_in_n ? GATE_BLOCK : GATE_HOLD;
          timer_clear = 1'b1;
        end
      end
      GATE_HOLD: begin
        if (sys_rst_n) begin
          state_d = GATE_PASS;
        end else if (ce_in_n || expired) begin
          state_d = GATE_BLOCK;
        end else begin
          timer_advance = 1'b1;
        end
      end
      GATE_BLOCK: begin
        if (sys_rst_n) begin
          state_d = GATE_PASS;
        end
      end
      default: begin
        state_d = GATE_BLOCK;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    state_q <= state_d;
  end

  assign path_open = (state_q == GATE_PASS) || (state_q == GATE_HOLD);

endmodule

// File: rtl/ce_out_stage.sv
module ce_out_stage (
  input  logic path_open,
  input  logic ce_in_n,
  output logic ce_out_n
);

  // A closed path drives the inactive (high) level.
  assign ce_out_n = path_open ? ce_in_n : 1'b1;

endmodule

// File: rtl/ce_reset_gate.sv
module ce_reset_gate
  import ce_gate_pkg::*;
#(
  parameter int GRACE_TICKS = 2500
) (
  input  logic clk,
  input  logic sys_rst_n,
  input  logic ce_in_n,
  output logic ce_out_n
);

  gate_state_e state_q;
  logic        expired;
  logic        timer_clear;
  logic        timer_advance;
  logic        path_open;

  ce_grace_timer #(
    .TICKS(GRACE_TICKS)
  ) i_timer (
    .clk     (clk),
    .clear   (timer_clear),
    .advance (timer_advance),
    .expired (expired)
  );

  ce_gate_ctrl i_ctrl (
    .clk           (clk),
    .sys_rst_n     (sys_rst_n),
    .ce_in_n       (ce_in_n),
    .expired       (expired),
    .state_q       (state_q),
    .timer_clear   (timer_clear),
    .timer_advance (timer_advance),
    .path_open     (path_open)
  );

  ce_out_stage i_out (
    .path_open (path_open),
    .ce_in_n   (ce_in_n),
    .ce_out_n  (ce_out_n)
  );

endmodule

// File: rtl/ce_reset_gate_chk.sv
module ce_reset_gate_chk
  import ce_gate_pkg::*;
#(
  parameter int GRACE_TICKS = 2500
) (
  input logic        clk,
  input logic        sys_rst_n,
  input logic        ce_in_n,
  input logic        ce_out_n,
  input gate_state_e state
);

  logic        armed_q = 1'b0;
  int unsigned low_run_q = 0;

  always_ff @(posedge clk) begin
    armed_q <= 1'b1;
    if (sys_rst_n) begin
      low_run_q <= 0;
    end else if (low_run_q <= GRACE_TICKS) begin
      low_run_q <= low_run_q + 1;
    end
  end

  assert_passthrough_R1: assert property (@(posedge clk) disable iff (!armed_q)
    (sys_rst_n && $past(sys_rst_n)) |-> (ce_out_n == ce_in_n));

  assert_idle_entry_blocks_R2: assert property (@(posedge clk) disable iff (!armed_q)
    (!sys_rst_n && $past(sys_rst_n) && ce_in_n) |=> ce_out_n);

  assert_release_ends_grace_R3: assert property (@(posedge clk) disable iff (!armed_q)
    (state == GATE_HOLD && !sys_rst_n && ce_in_n) |=> ce_out_n);

  assert_grace_bounded_R4: assert property (@(posedge clk) disable iff (!armed_q)
    (!sys_rst_n && low_run_q > GRACE_TICKS) |-> ce_out_n);

  assert_block_holds_R5: assert property (@(posedge clk) disable iff (!armed_q)
    (state == GATE_BLOCK && !sys_rst_n) |=> (state == GATE_BLOCK && ce_out_n));

  assert_reopen_R6: assert property (@(posedge clk) disable iff (!armed_q)
    $rose(sys_rst_n) |=> (ce_out_n == ce_in_n));

endmodule

bind ce_reset_gate ce_reset_gate_chk #(
  .GRACE_TICKS(GRACE_TICKS)
) i_chk (
  .clk       (clk),
  .sys_rst_n (sys_rst_n),
  .ce_in_n   (ce_in_n),
  .ce_out_n  (ce_out_n),
  .state     (state_q)
);

// File: tb/test_ce_reset_gate.sv
module test_ce_reset_gate;

  localparam int G = 12;

  logic clk = 1'b0;
  logic sys_rst_n;
  logic ce_in_n;
  logic ce_out_n;

  int n_cmp = 0;
  int n_bad = 0;
  int low_edges;
  bit seen_high;
  bit done = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  always #2 clk = ~clk;

  ce_reset_gate #(.GRACE_TICKS(G)) i_ce_reset_gate (
    .clk       (clk),
    .sys_rst_n (sys_rst_n),
    .ce_in_n   (ce_in_n),
    .ce_out_n  (ce_out_n)
  );

  // Drive away from the edge, compare, then advance the model on the edge.
  task automatic cyc(input logic ce, input logic rn, input string tag);
    logic exp;
    @(negedge clk);
    ce_in_n   = ce;
    sys_rst_n = rn;
    #1;
    if (low_edges == 0) exp = ce;
    else if (seen_high || low_edges > G) exp = 1'b1;
    else exp = ce;
    n_cmp++;
    if (ce_out_n !== exp) begin
      n_bad++;
      $display("FAIL %s: t=%0t ce_out_n=%b expected %b", tag, $time, ce_out_n, exp);
    end
    @(posedge clk);
    if (rn) begin
      low_edges = 0;
      seen_high = 1'b0;
    end else begin
      low_edges++;
      if (ce) seen_high = 1'b1;
    end
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not end, actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    sys_rst_n = 1'b0;
    ce_in_n   = 1'b1;
    repeat (2) @(posedge clk);
    low_edges = 3;
    seen_high = 1'b1;

    // R8 / R5: power-up in reset, chip-enable toggles but output stays high
    cyc(1'b1, 1'b0, "R8");
    cyc(1'b0, 1'b0, "R5");
    cyc(1'b0, 1'b0, "R5");
    // R6: release driven but not yet sampled, path still closed, then open
    cyc(1'b0, 1'b1, "R6");
    cyc(1'b0, 1'b1, "R6");
    // R1: passthrough pattern
    for (int i = 0; i < 10; i++) cyc(logic'(i % 3 == 0), 1'b1, "R1");
    // R2: enter reset with idle chip-enable, then try to write
    cyc(1'b1, 1'b0, "R2");
    for (int i = 0; i < 6; i++) cyc(logic'(i[0]), 1'b0, "R2");
    cyc(1'b0, 1'b1, "R6");
    cyc(1'b1, 1'b1, "R1");
    // R7 then R3: enter with active write, finish it early
    cyc(1'b0, 1'b0, "R7");
    for (int i = 0; i < 4; i++) cyc(1'b0, 1'b0, "R7");
    cyc(1'b1, 1'b0, "R3");
    for (int i = 0; i < 5; i++) cyc(1'b0, 1'b0, "R3");
    cyc(1'b1, 1'b1, "R6");
    cyc(1'b0, 1'b1, "R1");
    // R4: write never ends, window must time out
    for (int i = 0; i < G + 6; i++) cyc(1'b0, 1'b0, "R4");
    cyc(1'b0, 1'b1, "R6");
    cyc(1'b0, 1'b1, "R1");
    // R6: reset released during the window
    for (int i = 0; i < 4; i++) cyc(1'b0, 1'b0, "R7");
    cyc(1'b0, 1'b1, "R6");
    cyc(1'b1, 1'b1, "R1");
    cyc(1'b0, 1'b1, "R1");
    // Mixed pseudo-random traffic over all rules
    for (int i = 0; i < 400; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      cyc(lfsr[0] | lfsr[5], ~(lfsr[3] & lfsr[7] & lfsr[9]), "R5");
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule